// File: doc/BRIEF.md
# Cascade Match Priority Chain

This block is the per-device cascade logic of an associative memory that is stacked with identical devices into a deeper system. Each device receives three chain inputs from its higher-priority neighbour: any match so far, multiple match so far, and all full so far. It merges them with its own compare results and hands the merged chain outputs to its lower-priority neighbour. The same chain decides which single device may drive the shared data and address output buses when a command reads the highest-priority match or the status word.

The device's own match and multiple-match results are taken from the compare logic only when the active-low enable strobe rises at the end of a compare cycle. They are held unchanged while the strobe is low and through cycles that are not compares. The match chain therefore resolves only after the strobe has risen. The local full flag is a level that is registered every clock. The first device in a stack ties its chain inputs to their idle levels: no match, no multiple match, and all upstream full.

Top module: `cascade_chain`

## Requirements
- R1: After reset the held match and held multiple-match flags are 0, so with idle chain inputs matchOut, multiOut, every dataOe lane and addrOe are 0.
- R2: isCompare is sampled on the clock edge where strobeN is first seen low. If it was 1, localMatch and localMulti are captured on the edge where strobeN is first seen high again. The chain outputs reflect the captured values from that edge onward.
- R3: The held flags do not change while strobeN is low, whatever localMatch and localMulti do. A strobe cycle with isCompare 0 at its falling edge leaves them unchanged.
- R4: matchOut equals matchIn OR the held match flag.
- R5: multiOut equals multiIn OR the held multiple-match flag OR (matchIn AND held match flag).
- R6: localFull is registered once per clock. fullOut equals fullIn AND that registered value.
- R7: addrOe and every bit of dataOe (one bit per byte lane) equal condRead AND held match AND NOT matchIn. Only the highest-priority matching device enables its buses.
- R8: With the first-device ties (matchIn 0, multiIn 0, fullIn 1) the outputs follow the local state alone: matchOut is the held match, multiOut is the held multiple match, and fullOut is the registered full flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobeN | input | 1 | Enable strobe, active low; its rise ends a cycle |
| isCompare | input | 1 | Current strobe cycle is a compare |
| localMatch | input | 1 | Local compare found a match |
| localMulti | input | 1 | Local compare found several matches |
| localFull | input | 1 | Local array has no free location |
| condRead | input | 1 | Command reads highest-priority match or status |
| matchIn | input | 1 | Some higher-priority device matched |
| multiIn | input | 1 | Multiple match already seen upstream |
| fullIn | input | 1 | Every higher-priority device is full |
| matchOut | output | 1 | Match chain to the next device |
| multiOut | output | 1 | Multiple-match chain to the next device |
| fullOut | output | 1 | Full chain to the next device |
| dataOe | output | DATA_W/8 | Data bus output enable per byte lane |
| addrOe | output | 1 | Address bus output enable |

## Verification
The hardest case to reach is a change in the local compare results while the strobe is still low, or during a strobe cycle that is not a compare. In either case the chain must show the previously captured flags. The bench runs a compare cycle to set known held flags. It then holds the strobe low for several clocks while it toggles localMatch and localMulti, and it checks the chain outputs on each of those clocks. Finally it runs a full strobe cycle with isCompare raised only after the falling edge, which must not capture anything.

// File: rtl/cascade_pkg.sv
package cascade_pkg;
  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic capture;   // latch local compare flags this edge
  } ctrlStrobe_t;
endpackage

// File: rtl/cascade_ctrl.sv
module cascade_ctrl
  import cascade_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        strobeN,
  input  logic        isCompare,
  output ctrlStrobe_t ctrl
);
  logic strobeQ;
  logic cmpPend;
  logic strobeFall;
  logic strobeRise;

  assign strobeFall = strobeQ & ~strobeN;
  assign strobeRise = ~strobeQ & strobeN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ <= 1'b1;
      cmpPend <= 1'b0;
    end else begin
      strobeQ <= strobeN;
      if (strobeFall)      cmpPend <= isCompare;
      else if (strobeRise) cmpPend <= 1'b0;
    end
  end

  assign ctrl.capture = strobeRise & cmpPend;

  // R2
  capture_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |-> (strobeN && !strobeQ));

  // R3
  no_capture_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |-> !ctrl.capture);
endmodule

// File: rtl/cascade_datapath.sv
module cascade_datapath
  import cascade_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      ctrl,
  input  logic             strobeN,
  input  logic             localMatch,
  input  logic             localMulti,
  input  logic             localFull,
  input  logic             condRead,
  input  logic             matchIn,
  input  logic             multiIn,
  input  logic             fullIn,
  output logic             matchOut,
  output logic             multiOut,
  output logic             fullOut,
  output logic [LANES-1:0] dataOe,
  output logic             addrOe
);
  logic heldMatch;
  logic heldMulti;
  logic fullReg;
  logic ownBus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldMatch <= 1'b0;
      heldMulti <= 1'b0;
      fullReg   <= 1'b0;
    end else begin
      fullReg <= localFull;
      if (ctrl.capture) begin
        heldMatch <= localMatch;
        heldMulti <= localMulti;
      end
    end
  end

  assign matchOut = matchIn | heldMatch;
  assign multiOut = multiIn | heldMulti | (matchIn & heldMatch);
  assign fullOut  = fullIn & fullReg;
  assign ownBus   = condRead & heldMatch & ~matchIn;
  assign addrOe   = ownBus;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dataOe[g] = ownBus;
  end

  // R3
  held_stable_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |=> ($stable(heldMatch) && $stable(heldMulti)));

  // R2
  held_change_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(heldMatch) && $stable(heldMulti)));

  // R7
  oe_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe || (dataOe != '0)) |-> (heldMatch && !matchIn && condRead));

  // R6
  full_chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    fullOut |-> (fullIn && $past(localFull)));

  // R5
  multi_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!matchIn && !multiIn && !heldMulti) |-> !multiOut);
endmodule

// File: rtl/cascade_chain.sv
module cascade_chain
  import cascade_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobeN,
  input  logic             isCompare,
  input  logic             localMatch,
  input  logic             localMulti,
  input  logic             localFull,
  input  logic             condRead,
  input  logic             matchIn,
  input  logic             multiIn,
  input  logic             fullIn,
  output logic             matchOut,
  output logic             multiOut,
  output logic             fullOut,
  output logic [LANES-1:0] dataOe,
  output logic             addrOe
);
  ctrlStrobe_t ctrl;

  cascade_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strobeN(strobeN),
    .isCompare(isCompare), .ctrl(ctrl)
  );

  cascade_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .strobeN(strobeN),
    .localMatch(localMatch), .localMulti(localMulti),
    .localFull(localFull), .condRead(condRead),
    .matchIn(matchIn), .multiIn(multiIn), .fullIn(fullIn),
    .matchOut(matchOut), .multiOut(multiOut), .fullOut(fullOut),
    .dataOe(dataOe), .addrOe(addrOe)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!addrOe && dataOe == '0));
endmodule

// File: tb/cascade_chain_tb.sv
module cascade_chain_tb;
  localparam int LANES = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobeN = 1'b1, isCompare = 1'b0;
  logic localMatch = 1'b0, localMulti = 1'b0, localFull = 1'b0;
  logic condRead = 1'b0, matchIn = 1'b0, multiIn = 1'b0, fullIn = 1'b1;
  logic matchOut, multiOut, fullOut, addrOe;
  logic [LANES-1:0] dataOe;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cascade_chain #(.DATA_W(32)) u_dut (.*);

  // row: [7]lm [6]lmu [5]matchIn [4]multiIn [3]condRead [2]expMatch [1]expMulti [0]expOe
  localparam logic [7:0] VEC [8] = '{
    8'b00001000, 8'b10001101, 8'b10101110, 8'b11001111,
    8'b00111110, 8'b10000100, 8'b00101100, 8'b11111110};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobeCycle(logic lm, logic lmu, logic cmp);
    @(negedge clk);
    strobeN = 1'b0; isCompare = cmp; localMatch = lm; localMulti = lmu;
    @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
    localMatch = ~lm; localMulti = ~lmu; isCompare = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    condRead = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 matchOut", matchOut, 0);
    chk("R1 multiOut", multiOut, 0);
    chk("R1 oe", {dataOe, addrOe}, 0);

    // R4 R5 R7 table
    foreach (VEC[i]) begin
      matchIn = 1'b0; multiIn = 1'b0; condRead = 1'b0;
      strobeCycle(VEC[i][7], VEC[i][6], 1'b1);
      matchIn = VEC[i][5]; multiIn = VEC[i][4]; condRead = VEC[i][3];
      #1;
      chk("R4 matchOut", matchOut, VEC[i][2]);
      chk("R5 multiOut", multiOut, VEC[i][1]);
      chk("R7 addrOe", addrOe, VEC[i][0]);
      chk("R7 dataOe", dataOe, {LANES{VEC[i][0]}});
    end

    // R2 capture timing: held value appears at the edge where strobe seen high
    matchIn = 1'b0; multiIn = 1'b0; condRead = 1'b1;
    strobeCycle(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    strobeN = 1'b0; isCompare = 1'b1; localMatch = 1'b1; localMulti = 1'b1;
    @(negedge clk);
    strobeN = 1'b1;
    chk("R2 before rise edge", matchOut, 0);
    @(negedge clk);
    chk("R2 after rise edge", {matchOut, multiOut}, 2'b11);
    localMatch = 1'b0; localMulti = 1'b0; isCompare = 1'b0;

    // R3 strobe held low, local flags toggling
    @(negedge clk);
    strobeN = 1'b0; isCompare = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      localMatch = k[0]; localMulti = k[0];
      chk("R3 held while low", {matchOut, multiOut}, 2'b11);
    end
    localMatch = 1'b0; localMulti = 1'b0;
    @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
    chk("R2 capture after long low", {matchOut, multiOut}, 2'b00);

    // R3 non-compare cycle; isCompare raised only after the fall
    @(negedge clk);
    strobeN = 1'b0; isCompare = 1'b0; localMatch = 1'b1; localMulti = 1'b1;
    @(negedge clk);
    isCompare = 1'b1;
    @(negedge clk);
    strobeN = 1'b1;
    @(negedge clk);
    isCompare = 1'b0;
    chk("R3 non-compare ignored", {matchOut, multiOut, addrOe}, 3'b000);

    // R6 full chain
    fullIn = 1'b1; localFull = 1'b1;
    #1;
    chk("R6 registered delay", fullOut, 0);
    @(negedge clk);
    chk("R6 all full", fullOut, 1);
    fullIn = 1'b0; #1;
    chk("R6 upstream not full", fullOut, 0);
    fullIn = 1'b1; localFull = 1'b0;
    @(negedge clk);
    chk("R6 local not full", fullOut, 0);

    // R8 first-device ties
    matchIn = 1'b0; multiIn = 1'b0; fullIn = 1'b1; localFull = 1'b1;
    strobeCycle(1'b1, 1'b0, 1'b1);
    localFull = 1'b1;
    @(negedge clk);
    chk("R8 first device", {matchOut, multiOut, fullOut, addrOe}, 4'b1011);

    // R1 reset clears held flags
    rstN = 1'b0; #1;
    chk("R1 reset clears", {matchOut, addrOe, dataOe}, 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule